// File: doc/BRIEF.md
# Flash Page Write-Protect Lock Register

This block guards a small flash array of 224 bytes, organised as seven pages of 32 bytes each, against program and erase operations. It holds one lock bit per page in a register at the fixed register address 0x101. A bit that reads 1 leaves its page open. A bit that reads 0 shuts the page for good, until the next full reset.

The register is changed only through a memory-write transfer that the bus side has already checked with a CRC and then confirmed with the program code 0x5A. The stored value can only lose ones: each accepted write ANDs the written byte into the current value. Every flash request gives its target address and an operation kind (program or erase). The block answers one cycle later with a done strobe and exactly one of grant or deny. The flash cells, the serial front end and the CRC calculation are outside the block.

Top module: `page_lock_guard`

## Requirements
- R1: While rst_n is low at a clock edge, the register is set so that rd_value reads 0xFF and page_open reads 7'h7F. No response is pending after reset: op_done, op_grant and op_deny are all 0.
- R2: A write is applied only when wr_valid=1, wr_addr=0x101, wr_crc_ok=1 and wr_code=0x5A are all present at the same clock edge. Any other combination leaves rd_value unchanged.
- R3: An applied write sets the page bits to their current value ANDed with wr_data[6:0]. It takes effect on rd_value in the cycle after the edge that accepts it, and a bit at 0 never returns to 1 until reset.
- R4: Bit 7 of rd_value always reads 1, whatever was written to wr_data[7].
- R5: Page n (n = 0..6) covers flash addresses 32n through 32n+31, so page n is selected by op_addr[7:5] = n. A request to a page whose bit is 1 is granted.
- R6: A request to a page whose bit is 0 is denied, for program (op_erase=0) and for erase (op_erase=1) alike.
- R7: A request with op_addr at 0xE0 or above lies outside every page and is denied.
- R8: A request presented with op_valid=1 at a clock edge produces op_done=1 in the following cycle. In that cycle exactly one of op_grant or op_deny is 1, and op_kind echoes op_erase. When op_done=0, op_grant and op_deny are 0. The decision uses the lock value from before any write accepted at the same edge.
- R9: page_open always equals rd_value[6:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Register write request |
| wr_addr | input | 12 | Register address of the write |
| wr_data | input | 8 | Written byte, where 0 bits lock pages |
| wr_code | input | 8 | Confirmation code, must be 0x5A |
| wr_crc_ok | input | 1 | Transfer passed its CRC check |
| op_valid | input | 1 | Flash operation request |
| op_addr | input | 8 | Flash byte address of the request |
| op_erase | input | 1 | 1 = erase, 0 = program |
| rd_value | output | 8 | Current register value, bit 7 fixed at 1 |
| page_open | output | 7 | Per-page status, 1 = page writable |
| op_done | output | 1 | Response strobe, one cycle after the request |
| op_grant | output | 1 | Operation allowed |
| op_deny | output | 1 | Operation refused |
| op_kind | output | 1 | Operation kind of the answered request |

## Verification
A write accepted at edge k shows up on rd_value and page_open from edge k onward, so the bench first checks it in the half-cycle after that edge. A request presented at edge k is answered by op_done, op_grant, op_deny and op_kind in that same half-cycle. The bench drives inputs on the falling edge and updates its behavioural model once per rising edge. It uses the pre-write lock value for the request decision, then compares every output a quarter period after the edge. This places the check for a request and a write in the same cycle exactly where the old lock value must still govern the answer.

// File: rtl/plk_pkg.sv
// Shared constants for the page lock guard.
// Assumes the page count times the page size fits the flash address space.
package plk_pkg;
    localparam int REG_ADDR_W   = 12;
    localparam int DATA_W       = 8;
    localparam int FLASH_ADDR_W = 8;
    localparam int PAGE_SHIFT   = 5;
    localparam int NUM_PAGES    = 7;
    localparam logic [REG_ADDR_W-1:0] LOCK_REG_ADDR = 12'h101;
    localparam logic [DATA_W-1:0]     CONFIRM_CODE  = 8'h5A;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } flash_op_e;
endpackage

// File: rtl/plk_lock_reg.sv
// One-way lock register. It accepts a write only when the address, the CRC flag
// and the confirmation code all qualify, and it can only clear bits.
// Assumes DATA_W > NUM_PAGES; the bits above the pages are not stored.
module plk_lock_reg #(
    parameter int REG_ADDR_W = 12,
    parameter int DATA_W     = 8,
    parameter int NUM_PAGES  = 7,
    parameter logic [REG_ADDR_W-1:0] REG_ADDR = 12'h101,
    parameter logic [DATA_W-1:0]     CODE     = 8'h5A
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [DATA_W-1:0]     wr_code,
    input  logic                  wr_crc_ok,
    output logic [NUM_PAGES-1:0]  open_q
);
    logic take;
    logic unused_hi;

    // Qualify a write: every condition must hold in the same cycle.
    always_comb begin
        take = wr_valid && wr_crc_ok && (wr_addr == REG_ADDR) && (wr_code == CODE);
    end

    assign unused_hi = ^wr_data[DATA_W-1:NUM_PAGES];

    // Storage: reset opens every page; an accepted write may only clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= '1;
        end else if (take) begin
            open_q <= open_q & wr_data[NUM_PAGES-1:0];
        end
    end

    // R2: without a qualified write the register holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(open_q));

    // R3: no bit ever goes from 0 back to 1
    p_only_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((open_q & ~$past(open_q)) == '0));
endmodule

// File: rtl/plk_page_decode.sv
// Combinational page decode. It maps a flash address to its page and reports
// whether the page is open. Addresses beyond the last page match no page.
module plk_page_decode #(
    parameter int FLASH_ADDR_W = 8,
    parameter int PAGE_SHIFT   = 5,
    parameter int NUM_PAGES    = 7
) (
    input  logic [FLASH_ADDR_W-1:0] addr,
    input  logic [NUM_PAGES-1:0]    open_pages,
    output logic                    allowed
);
    localparam int IDX_W = FLASH_ADDR_W - PAGE_SHIFT;

    logic [NUM_PAGES-1:0] hit;
    logic unused_lo;

    assign unused_lo = ^addr[PAGE_SHIFT-1:0];

    // One comparator per page window.
    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        localparam logic [IDX_W-1:0] PIDX = IDX_W'(p);
        assign hit[p] = (addr[FLASH_ADDR_W-1:PAGE_SHIFT] == PIDX);
    end

    // Allowed only when the addressed page exists and is open.
    always_comb begin
        allowed = |(hit & open_pages);
    end

    // at most one window can match any address
    always_comb begin
        a_hit_onehot_r5: assert ($onehot0(hit));
    end
endmodule

// File: rtl/plk_req_gate.sv
// Response register. It captures the grant decision together with the request
// strobe so that each request is answered exactly one cycle later.
module plk_req_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_erase,
    input  logic req_allowed,
    output logic rsp_done,
    output logic rsp_grant,
    output logic rsp_deny,
    output logic rsp_kind
);
    // Register the handshake and the decision side by side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_deny  <= 1'b0;
            rsp_kind  <= plk_pkg::OP_PROGRAM;
        end else begin
            rsp_done  <= req_valid;
            rsp_grant <= req_valid && req_allowed;
            rsp_deny  <= req_valid && !req_allowed;
            rsp_kind  <= req_valid ? req_erase : rsp_kind;
        end
    end

    // R8: each request answered on the next cycle
    p_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_done);
    // R8: a done strobe carries exactly one verdict
    p_one_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rsp_grant ^ rsp_deny));
    // R8: no verdict without a done strobe
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> !(rsp_grant || rsp_deny));
endmodule

// File: rtl/page_lock_guard.sv
// Flash page write-protect guard. It holds one one-way lock bit per page and
// answers each program or erase request with a registered grant or deny.
// Assumes the CRC check happens upstream and arrives as wr_crc_ok.
module page_lock_guard
    import plk_pkg::*;
#(
    parameter int RA_W  = REG_ADDR_W,
    parameter int D_W   = DATA_W,
    parameter int FA_W  = FLASH_ADDR_W,
    parameter int SHIFT = PAGE_SHIFT,
    parameter int PAGES = NUM_PAGES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    input  logic [RA_W-1:0] wr_addr,
    input  logic [D_W-1:0]  wr_data,
    input  logic [D_W-1:0]  wr_code,
    input  logic            wr_crc_ok,
    input  logic            op_valid,
    input  logic [FA_W-1:0] op_addr,
    input  logic            op_erase,
    output logic [D_W-1:0]  rd_value,
    output logic [PAGES-1:0] page_open,
    output logic            op_done,
    output logic            op_grant,
    output logic            op_deny,
    output logic            op_kind
);
    localparam int IDX_W = FA_W - SHIFT;
    localparam int SLOTS = 2 ** IDX_W;
    localparam logic [FA_W:0] SPAN = (FA_W + 1)'(PAGES << SHIFT);

    logic [PAGES-1:0] open_q;
    logic             allowed;
    logic [SLOTS-1:0] open_ext;

    plk_lock_reg #(
        .REG_ADDR_W(RA_W), .DATA_W(D_W), .NUM_PAGES(PAGES),
        .REG_ADDR(RA_W'(LOCK_REG_ADDR)), .CODE(D_W'(CONFIRM_CODE))
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_code(wr_code), .wr_crc_ok(wr_crc_ok),
        .open_q(open_q)
    );

    plk_page_decode #(
        .FLASH_ADDR_W(FA_W), .PAGE_SHIFT(SHIFT), .NUM_PAGES(PAGES)
    ) u_dec (
        .addr(op_addr), .open_pages(open_q), .allowed(allowed)
    );

    plk_req_gate u_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(op_valid), .req_erase(op_erase),
        .req_allowed(allowed), .rsp_done(op_done), .rsp_grant(op_grant),
        .rsp_deny(op_deny), .rsp_kind(op_kind)
    );

    // Read view: the unused upper bits always read as 1.
    assign rd_value  = {{(D_W - PAGES){1'b1}}, open_q};
    assign page_open = open_q;
    assign open_ext  = {{(SLOTS - PAGES){1'b0}}, open_q};

    // R4: reserved bit reads as 1
    always_comb begin
        a_rsvd_r4: assert (rd_value[D_W-1] == 1'b1);
    end

    // R6: a request to a locked page is refused
    p_locked_deny_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ({1'b0, op_addr} < SPAN) && !open_ext[op_addr[FA_W-1:SHIFT]])
        |=> op_deny);

    // R7: addresses past the last page are refused
    p_out_of_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ({1'b0, op_addr} >= SPAN)) |=> op_deny);
endmodule

// File: tb/sim_page_lock_guard.sv
// Bench for page_lock_guard. A behavioural reference model is stepped once per
// rising edge and all outputs are compared a quarter period after each edge.
module sim_page_lock_guard;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_valid, wr_crc_ok, op_valid, op_erase;
    logic [11:0] wr_addr;
    logic [7:0]  wr_data, wr_code, op_addr;
    logic [7:0]  rd_value;
    logic [6:0]  page_open;
    logic        op_done, op_grant, op_deny, op_kind;

    int vectors = 0;
    int misses  = 0;

    // reference model state
    int m_lock = 255;
    int m_done = 0, m_grant = 0, m_deny = 0, m_kind = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_lock_guard u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_code(wr_code), .wr_crc_ok(wr_crc_ok),
        .op_valid(op_valid), .op_addr(op_addr), .op_erase(op_erase),
        .rd_value(rd_value), .page_open(page_open), .op_done(op_done),
        .op_grant(op_grant), .op_deny(op_deny), .op_kind(op_kind)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Advance one cycle with the given inputs, step the model, compare outputs.
    task automatic cyc(input string tag,
                       input bit wv, input int wa, input int wd, input int wc, input bit wok,
                       input bit ov, input int oa, input bit oe, input bit rst = 1'b1);
        int page;
        bit open;
        rst_n = rst; wr_valid = wv; wr_addr = 12'(wa); wr_data = 8'(wd);
        wr_code = 8'(wc); wr_crc_ok = wok; op_valid = ov; op_addr = 8'(oa); op_erase = oe;
        @(posedge clk);
        if (!rst) begin
            m_lock = 255; m_done = 0; m_grant = 0; m_deny = 0; m_kind = 0;
        end else begin
            page = oa / 32;
            open = (page < 7) && (((m_lock >> page) & 1) == 1);
            m_done = ov; m_grant = ov && open; m_deny = ov && !open;
            if (ov) m_kind = oe;
            if (wv && wa == 'h101 && wok && wc == 'h5A)
                m_lock = (m_lock & wd) | 128;
        end
        #(CLK_PERIOD/4);
        check(tag, "rd_value", int'(rd_value), m_lock);
        check("R9", "page_open", int'(page_open), m_lock % 128);
        check(tag, "op_done", int'(op_done), m_done);
        check(tag, "op_grant", int'(op_grant), m_grant);
        check(tag, "op_deny", int'(op_deny), m_deny);
        if (m_done != 0) check("R8", "op_kind", int'(op_kind), m_kind);
        @(negedge clk);
    endtask

    task automatic wr(input string tag, input int wa, input int wd, input int wc, input bit wok);
        cyc(tag, 1'b1, wa, wd, wc, wok, 1'b0, 0, 1'b0);
    endtask

    task automatic req(input string tag, input int oa, input bit oe);
        cyc(tag, 1'b0, 0, 0, 0, 1'b0, 1'b1, oa, oe);
    endtask

    // watchdog: an expired run counts as a failed check
    initial begin
        #(CLK_PERIOD * 20000);
        misses++;
        vectors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        cyc("R1", 1'b1, 'h101, 'h00, 'h5A, 1'b1, 1'b1, 0, 1'b0, 1'b0);
        cyc("R1", 1'b0, 0, 0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        check("R1", "rd_value reset", int'(rd_value), 'hFF);
        check("R1", "op_done reset", int'(op_done), 0);
        // R5: every page boundary granted, program and erase
        for (int n = 0; n < 7; n++) begin
            req("R5", 32 * n, 1'b0);
            req("R5", 32 * n + 31, 1'b1);
        end
        // R7: beyond the last page
        req("R7", 'hE0, 1'b0);
        req("R7", 'hFF, 1'b1);
        // R2: each missing qualifier blocks the write
        wr("R2", 'h101, 'hFB, 'h5B, 1'b1);
        wr("R2", 'h101, 'hFB, 'h5A, 1'b0);
        wr("R2", 'h100, 'hFB, 'h5A, 1'b1);
        cyc("R2", 1'b0, 'h101, 'hFB, 'h5A, 1'b1, 1'b0, 0, 1'b0);
        req("R2", 'h40, 1'b0);
        // R3: valid write locks page 2
        wr("R3", 'h101, 'hFB, 'h5A, 1'b1);
        req("R6", 'h40, 1'b0);
        req("R6", 'h5F, 1'b1);
        req("R5", 'h3F, 1'b0);
        // R3: writing ones never unlocks
        wr("R3", 'h101, 'hFF, 'h5A, 1'b1);
        req("R3", 'h44, 1'b1);
        // R4: bit 7 written as 0 still reads 1
        wr("R4", 'h101, 'h7F, 'h5A, 1'b1);
        check("R4", "bit7", int'(rd_value[7]), 1);
        wr("R3", 'h101, 'hAE, 'h5A, 1'b1);
        req("R6", 'h00, 1'b1);
        req("R6", 'hC5, 1'b0);
        req("R5", 'h25, 1'b0);
        // R8: write and request at the same edge use the old value
        cyc("R8", 1'b1, 'h101, 'hF7, 'h5A, 1'b1, 1'b1, 'h60, 1'b1);
        req("R8", 'h60, 1'b0);
        cyc("R8", 1'b0, 0, 0, 0, 1'b0, 1'b0, 0, 1'b0);
        // R1: a new reset reopens all pages
        cyc("R1", 1'b0, 0, 0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        check("R1", "rd_value after reset", int'(rd_value), 'hFF);
        req("R5", 'h00, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule